// File: doc/BRIEF.md
# Timed-Token Station Controller

This block is the medium-access controller of a single station on a token-passing ring. It decides how long the station may keep the token each time the token arrives. Two rotation timers take turns. On each visit, one timer is cleared when the token arrives and then measures the fixed synchronous window. The other timer still holds the time since the previous visit, and it decides whether the station may use extra asynchronous time before it passes the token on. The timers swap roles on every visit, so the controller alternates between a Z phase and a Y phase.

Time is counted in ticks of a time-base enable input, not in clock cycles. A one-cycle token grant starts a visit. A one-cycle token release ends it. Status outputs show the current phase and window. Grants that arrive while the station already holds the token are dropped and recorded in a sticky error flag. The synchronous allocation and the target rotation time are parameters. With the defaults (1 and 25) each timer is 5 bits wide and stops at 26.

Top module: `timed_token_station`

## Requirements
- R1: Synchronous reset leaves the controller idle in the Z phase. Both timers are loaded to TARGET_ROT+1, which marks them as expired. The first visit after reset therefore gets no asynchronous window, even if `async_req` is high. All outputs read 0 after reset.
- R2: Encoding of `phase_y`: 0 means Z phase, 1 means Y phase.
  - A grant in Z idle clears timer Y and enters Z synchronous.
  - A grant in Y idle clears timer Z and enters Y synchronous.
  - Each release moves the controller to the idle state of the opposite phase.
- R3: The synchronous window (`in_sync`=1) stays open until the window timer has counted SYNC_ALLOC ticks since the grant. The window timer is Y in the Z phase and Z in the Y phase.
- R4: When the synchronous window ends, the controller checks the other timer.
  - If that timer + 1 <= TARGET_ROT, it enters the asynchronous window (`in_async`=1).
  - Otherwise it releases the token in the same cycle.
- R5: The asynchronous window ends in the first cycle in which `async_req` is low or the other timer is >= TARGET_ROT. On every release:
  - `token_release` is high for exactly one cycle;
  - the other timer is reloaded to TARGET_ROT+1;
  - in that same cycle the status outputs show idle in the opposite phase.
- R6: Each timer stops at TARGET_ROT+1. After a long idle period, a visit gets no asynchronous window.
- R7: A grant in a synchronous or asynchronous state has no effect on the state or the timers. It sets `proto_err`, which stays high until reset.
- R8: The timers advance only in cycles in which `tick_en` is high. With `tick_en` held low, a synchronous window never ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base enable; both timers advance when it is high |
| token_grant | input | 1 | One-cycle pulse: the token has arrived |
| async_req | input | 1 | Asynchronous traffic is waiting |
| token_release | output | 1 | One-cycle pulse: the token is passed on |
| phase_y | output | 1 | 0 = Z phase, 1 = Y phase |
| in_sync | output | 1 | Synchronous window open |
| in_async | output | 1 | Asynchronous window open |
| proto_err | output | 1 | Sticky flag: a grant arrived while the token was held |

## Verification
The hardest case to reach is an asynchronous window that the rotation timer cuts off while `async_req` is still high. To get there, the token must come back early enough that async is granted. The request must then stay high until the older timer reaches the target. The bench builds this case directly: it makes a quick second visit right after the reset visit and holds the request high for many cycles. A random phase then mixes grants, requests and sparse ticks. Throughout the run, a cycle-accurate reference of the requirements checks the release pulse, the phase, both windows and the error flag.

// File: rtl/tts_pkg.sv
package tts_pkg;
  typedef enum logic [2:0] {
    ST_Z_IDLE  = 3'd0,
    ST_Z_SYNC  = 3'd1,
    ST_Z_ASYNC = 3'd2,
    ST_Y_IDLE  = 3'd3,
    ST_Y_SYNC  = 3'd4,
    ST_Y_ASYNC = 3'd5
  } tts_state_e;
endpackage

// File: rtl/tts_rot_timer.sv
// Saturating rotation timer: reset/load to the expiry value, clear to zero.
module tts_rot_timer #(
  parameter int TARGET_ROT = 25,
  parameter int TW         = $clog2(TARGET_ROT + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          clr,
  input  logic          load_cap,
  output logic [TW-1:0] cnt
);
  localparam logic [TW-1:0] CAP_V = TW'(TARGET_ROT + 1);

  always_ff @(posedge clk) begin
    if (rst || load_cap) begin
      cnt <= CAP_V;
    end else if (clr) begin
      cnt <= '0;
    end else if (tick && (cnt != CAP_V)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tts_fsm.sv
// Six-state visit controller; Z and Y phases alternate on each release.
module tts_fsm
  import tts_pkg::*;
#(
  parameter int SYNC_ALLOC = 1,
  parameter int TARGET_ROT = 25,
  parameter int TW         = $clog2(TARGET_ROT + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grant,
  input  logic          async_req,
  input  logic [TW-1:0] tmr_z,
  input  logic [TW-1:0] tmr_y,
  output logic          clr_z,
  output logic          clr_y,
  output logic          load_z,
  output logic          load_y,
  output logic          token_release,
  output logic          phase_y,
  output logic          in_sync,
  output logic          in_async,
  output logic          proto_err
);
  localparam logic [TW-1:0] SA_V = TW'(SYNC_ALLOC);
  localparam logic [TW:0]   TG_W = (TW+1)'(TARGET_ROT);

  tts_state_e st_q, st_d;
  logic       y_now, rel_d, sync_done, early, async_done, busy;
  logic [TW-1:0] win_t, oth_t;

  always_comb begin
    y_now      = (st_q == ST_Y_IDLE) || (st_q == ST_Y_SYNC) || (st_q == ST_Y_ASYNC);
    win_t      = y_now ? tmr_z : tmr_y;
    oth_t      = y_now ? tmr_y : tmr_z;
    sync_done  = (win_t >= SA_V);
    early      = (({1'b0, oth_t} + 1'b1) <= TG_W);
    async_done = !async_req || ({1'b0, oth_t} >= TG_W);
    busy       = (st_q != ST_Z_IDLE) && (st_q != ST_Y_IDLE);
  end

  always_comb begin
    st_d   = st_q;
    rel_d  = 1'b0;
    clr_z  = 1'b0;
    clr_y  = 1'b0;
    load_z = 1'b0;
    load_y = 1'b0;
    unique case (st_q)
      ST_Z_IDLE: if (grant) begin
        clr_y = 1'b1;
        st_d  = ST_Z_SYNC;
      end
      ST_Z_SYNC: if (sync_done) begin
        if (early) begin
          st_d = ST_Z_ASYNC;
        end else begin
          rel_d  = 1'b1;
          load_z = 1'b1;
          st_d   = ST_Y_IDLE;
        end
      end
      ST_Z_ASYNC: if (async_done) begin
        rel_d  = 1'b1;
        load_z = 1'b1;
        st_d   = ST_Y_IDLE;
      end
      ST_Y_IDLE: if (grant) begin
        clr_z = 1'b1;
        st_d  = ST_Y_SYNC;
      end
      ST_Y_SYNC: if (sync_done) begin
        if (early) begin
          st_d = ST_Y_ASYNC;
        end else begin
          rel_d  = 1'b1;
          load_y = 1'b1;
          st_d   = ST_Z_IDLE;
        end
      end
      ST_Y_ASYNC: if (async_done) begin
        rel_d  = 1'b1;
        load_y = 1'b1;
        st_d   = ST_Z_IDLE;
      end
      default: st_d = ST_Z_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_Z_IDLE;
      token_release <= 1'b0;
      phase_y       <= 1'b0;
      in_sync       <= 1'b0;
      in_async      <= 1'b0;
      proto_err     <= 1'b0;
    end else begin
      st_q          <= st_d;
      token_release <= rel_d;
      phase_y       <= (st_d == ST_Y_IDLE) || (st_d == ST_Y_SYNC) || (st_d == ST_Y_ASYNC);
      in_sync       <= (st_d == ST_Z_SYNC) || (st_d == ST_Y_SYNC);
      in_async      <= (st_d == ST_Z_ASYNC) || (st_d == ST_Y_ASYNC);
      proto_err     <= proto_err || (grant && busy);
    end
  end
endmodule

// File: rtl/timed_token_station.sv
module timed_token_station #(
  parameter int SYNC_ALLOC = 1,
  parameter int TARGET_ROT = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic token_grant,
  input  logic async_req,
  output logic token_release,
  output logic phase_y,
  output logic in_sync,
  output logic in_async,
  output logic proto_err
);
  localparam int TW = $clog2(TARGET_ROT + 2);
  localparam int NT = 2;  // index 0: timer Z, index 1: timer Y

  logic [NT-1:0]  clr_v, load_v;
  logic [TW-1:0]  cnt_v [NT];
  logic [TW-1:0]  tmr_z, tmr_y;

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    tts_rot_timer #(.TARGET_ROT(TARGET_ROT), .TW(TW)) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick_en),
      .clr     (clr_v[i]),
      .load_cap(load_v[i]),
      .cnt     (cnt_v[i])
    );
  end

  assign tmr_z = cnt_v[0];
  assign tmr_y = cnt_v[1];

  tts_fsm #(.SYNC_ALLOC(SYNC_ALLOC), .TARGET_ROT(TARGET_ROT), .TW(TW)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .grant        (token_grant),
    .async_req    (async_req),
    .tmr_z        (tmr_z),
    .tmr_y        (tmr_y),
    .clr_z        (clr_v[0]),
    .clr_y        (clr_v[1]),
    .load_z       (load_v[0]),
    .load_y       (load_v[1]),
    .token_release(token_release),
    .phase_y      (phase_y),
    .in_sync      (in_sync),
    .in_async     (in_async),
    .proto_err    (proto_err)
  );
endmodule

// File: rtl/tts_station_checker.sv
module tts_station_checker #(
  parameter int SYNC_ALLOC = 1,
  parameter int TARGET_ROT = 25,
  parameter int TW         = $clog2(TARGET_ROT + 2)
) (
  input logic          clk,
  input logic          rst,
  input logic          token_grant,
  input logic          token_release,
  input logic          phase_y,
  input logic          in_sync,
  input logic          in_async,
  input logic          proto_err,
  input logic [TW-1:0] tmr_z,
  input logic [TW-1:0] tmr_y
);
  localparam logic [TW-1:0] CAP_V = TW'(TARGET_ROT + 1);
  localparam logic [TW-1:0] TG_V  = TW'(TARGET_ROT);
  localparam logic [TW-1:0] SA_V  = TW'(SYNC_ALLOC);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!phase_y && !in_sync && !in_async && !token_release && !proto_err));

  assert_one_window_R2: assert property (@(posedge clk) disable iff (rst)
    !(in_sync && in_async));

  assert_sync_bound_R3: assert property (@(posedge clk) disable iff (rst)
    in_sync |-> ((phase_y ? tmr_z : tmr_y) <= SA_V));

  assert_async_bound_R4: assert property (@(posedge clk) disable iff (rst)
    in_async |-> ((phase_y ? tmr_y : tmr_z) <= TG_V));

  assert_release_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    token_release |=> !token_release);

  assert_release_idle_R5: assert property (@(posedge clk) disable iff (rst)
    token_release |-> (!in_sync && !in_async && (phase_y ? tmr_z : tmr_y) == CAP_V));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (tmr_z <= CAP_V) && (tmr_y <= CAP_V));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  assert_busy_grant_R7: assert property (@(posedge clk) disable iff (rst)
    (token_grant && (in_sync || in_async)) |=> proto_err);
endmodule

bind timed_token_station tts_station_checker #(
  .SYNC_ALLOC(SYNC_ALLOC),
  .TARGET_ROT(TARGET_ROT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .token_grant  (token_grant),
  .token_release(token_release),
  .phase_y      (phase_y),
  .in_sync      (in_sync),
  .in_async     (in_async),
  .proto_err    (proto_err),
  .tmr_z        (tmr_z),
  .tmr_y        (tmr_y)
);

// File: tb/timed_token_station_bench.sv
module timed_token_station_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SA  = 1;
  localparam int TG  = 25;
  localparam int CAP = TG + 1;

  logic clk = 0, rst = 1, tick_en = 0, token_grant = 0, async_req = 0;
  logic token_release, phase_y, in_sync, in_async, proto_err;
  int n_chk = 0, n_fail = 0;
  bit saw_async, saw_rel;

  always #(CLK_PERIOD/2) clk = ~clk;

  timed_token_station #(.SYNC_ALLOC(SA), .TARGET_ROT(TG)) u_timed_token_station (
    .clk(clk), .rst(rst), .tick_en(tick_en), .token_grant(token_grant),
    .async_req(async_req), .token_release(token_release), .phase_y(phase_y),
    .in_sync(in_sync), .in_async(in_async), .proto_err(proto_err));

  // Reference model of the requirements: m_st 0..2 Z idle/sync/async, 3..5 Y.
  int m_st, m_tz, m_ty, nst, win, oth;
  bit m_rel, m_err, yph, cz, cy, lz, ly;

  function automatic int tmr_next(int v, bit c, bit l, bit t);
    if (l) return CAP;
    if (c) return 0;
    if (t && v < CAP) return v + 1;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_tz = CAP; m_ty = CAP; m_rel = 0; m_err = 0;
    end else begin
      yph = (m_st >= 3); win = yph ? m_tz : m_ty; oth = yph ? m_ty : m_tz;
      nst = m_st; cz = 0; cy = 0; lz = 0; ly = 0; m_rel = 0;
      case (m_st % 3)
        0: if (token_grant) begin nst = m_st + 1; if (yph) cz = 1; else cy = 1; end
        1: if (win >= SA) begin
             if (oth + 1 <= TG) nst = m_st + 1;
             else begin m_rel = 1; nst = yph ? 0 : 3; if (yph) ly = 1; else lz = 1; end
           end
        default: if (!async_req || oth >= TG) begin
             m_rel = 1; nst = yph ? 0 : 3; if (yph) ly = 1; else lz = 1;
           end
      endcase
      if (token_grant && (m_st % 3) != 0) m_err = 1;
      m_tz = tmr_next(m_tz, cz, lz, tick_en);
      m_ty = tmr_next(m_ty, cy, ly, tick_en);
      m_st = nst;
    end
  end

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: compare outputs with the model, then drive the next inputs.
  task automatic step(bit g, bit a, bit t);
    @(negedge clk);
    if (!rst) begin
      check("R5", token_release, m_rel);
      check("R2", phase_y, m_st >= 3);
      check("R3", in_sync, (m_st % 3) == 1);
      check("R4", in_async, (m_st % 3) == 2);
      check("R7", proto_err, m_err);
      if (in_async) saw_async = 1;
      if (token_release) saw_rel = 1;
    end
    token_grant = g; async_req = a; tick_en = t;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check("R1", phase_y, 0); check("R1", in_sync, 0); check("R1", in_async, 0);
    check("R1", token_release, 0); check("R1", proto_err, 0);

    // R1: first visit has expired timers, so no async even with request high
    saw_async = 0; saw_rel = 0;
    step(1, 1, 1);
    repeat (6) step(0, 1, 1);
    check("R1", saw_async, 0); check("R1", saw_rel, 1); check("R2", phase_y, 1);

    // R4/R5: quick return gets async; request held so the timer ends it
    saw_async = 0; saw_rel = 0;
    step(1, 1, 1);
    repeat (40) step(0, 1, 1);
    check("R4", saw_async, 1); check("R5", saw_rel, 1); check("R5", phase_y, 0);

    // R5: async ended by request low
    saw_async = 0;
    step(1, 1, 1);
    repeat (4) step(0, 1, 1);
    repeat (4) step(0, 0, 1);
    check("R5", in_async, 0);

    // R8: no ticks, synchronous window holds
    step(1, 0, 0);
    repeat (12) step(0, 0, 0);
    check("R8", in_sync, 1);
    repeat (6) step(0, 0, 1);
    check("R8", in_sync, 0);

    // R6: long idle saturates timers, next visit gets no async
    repeat (80) step(0, 1, 1);
    saw_async = 0;
    step(1, 1, 1);
    repeat (6) step(0, 1, 1);
    check("R6", saw_async, 0);

    // R7: grant while holding the token is ignored and sets the sticky flag
    step(1, 1, 1);
    step(1, 1, 1);
    step(0, 1, 1);
    check("R7", proto_err, 1);
    repeat (30) step(0, 0, 1);
    check("R7", proto_err, 1);

    // Reset clears the flag, then random traffic
    rst = 1; repeat (2) @(negedge clk); rst = 0;
    @(negedge clk);
    check("R1", proto_err, 0);
    for (int i = 0; i < 4000; i++)
      step(($urandom % 6) == 0, ($urandom % 4) != 0, ($urandom % 4) != 0);
    step(0, 0, 0);
    finish_run();
  end
endmodule